// File: doc/BRIEF.md
# Addressable LED Pulse-Width Decoder

This block watches one serial data line that drives a chain of addressable LEDs and recovers what was sent on it. A sample strobe marks the moments the line is read; at the nominal 8 MHz rate each sample stands for 125 ns. The block measures every high and low run in samples. It turns each high pulse into a data bit, or rejects it as a glitch. Bits are packed into 24-bit pixels. Long low stretches mark the gap between frames.

The decoder is meant for checking an LED driver on the wire. Every high pulse whose width falls outside the allowed windows raises a one-cycle glitch flag, together with the measured width. The typical case is a driver whose output holds high while its data feed is starved. A running bit count and a frame count give a quick view of throughput. A pixel cut short by a frame gap is dropped and flagged, so a short frame is never passed on as good data.

Top module: `led_pulse_decoder`

## Requirements
- R1: The line is read only on clock cycles where `sample_en_i` is high, and all widths are counted in strobes, however many clock cycles separate the strobes.
- R2: A high pulse of 2 or 3 samples decodes as bit 0, and a high pulse of 6, 7 or 8 samples decodes as bit 1. A high pulse ends at the first low sample.
- R3: A high pulse of any other width (1, 4, 5, or 9 and more samples) is not a bit. It raises `glitch_o` for one cycle, with its width on `glitch_width_o`.
- R4: Run counters saturate at 2^CNT_W-1 (511 by default), so a very long high reports a glitch of width 511 rather than a wrapped value.
- R5: A low run of more than GAP_LOW samples (400 by default, i.e. more than 50 µs) is a frame gap. The gap is recognised on the 401st consecutive low sample; a run of exactly 400 is not a gap.
- R6: After reset, all outputs and counters are zero, and no bit, pixel or glitch is produced until the first frame gap has been seen.
- R7: Bits are assembled MSB first. After every 24th bit of a frame, `pixel_valid_o` is high for one cycle with the pixel on `pixel_data_o`. Event outputs rise two clock cycles after the strobe that ends the pulse.
- R8: A frame gap that arrives with 1 to 23 bits of a pixel collected discards those bits and pulses `trunc_o`. A gap on a pixel boundary does not pulse it.
- R9: The first bit after a gap pulses `frame_start_o` and increments `frame_count_o`. Several gaps with no bit between them start only one frame.
- R10: `bit_count_o` counts every decoded bit since reset. Glitches and pulses before the first gap do not count.
- R11: A glitch inside a pixel leaves the bits already collected in place, and the pixel completes with the next valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | LED data line, already synchronous to clk_i |
| sample_en_i | input | 1 | Sample strobe |
| pixel_valid_o | output | 1 | One-cycle strobe for a completed pixel |
| pixel_data_o | output | 24 | Last completed pixel, first bit in MSB |
| frame_start_o | output | 1 | One-cycle pulse with the first bit of a frame |
| trunc_o | output | 1 | One-cycle pulse when a gap drops a partial pixel |
| glitch_o | output | 1 | One-cycle pulse for an out-of-window high pulse |
| glitch_width_o | output | 9 | Width in samples of the last glitch |
| bit_count_o | output | 32 | Decoded bits since reset |
| frame_count_o | output | 16 | Frames started since reset |

## Verification
The bench probes the edges of each width window: 1, 3, 4, 5, 6, 8 and 9 samples. A design that used an off-by-one bound would turn a legal edge width into a glitch, or let an illegal one through as a bit. It sets a low run of exactly 400 samples against one of 410. An early gap detector would truncate a pixel that should have completed. It also sends glitches in the middle of a pixel, a 600-sample high that must saturate at 511, back-to-back gaps, and activity before the first gap. A wrong design would show a shifted pixel, a wrapped width, an extra frame start, or bits decoded before the decoder is in sync. A slowed strobe checks that widths are counted in samples and not in clock cycles.

// File: rtl/led_dec_pkg.sv
package led_dec_pkg;
  typedef enum logic [1:0] {
    PK_ZERO   = 2'd0,
    PK_ONE    = 2'd1,
    PK_GLITCH = 2'd2
  } pulse_kind_e;
endpackage

// File: rtl/led_run_meter.sv
module led_run_meter #(
  parameter int CNT_W   = 9,
  parameter int GAP_LOW = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             sample_en_i,
  output logic             hi_done_o,
  output logic [CNT_W-1:0] hi_width_o,
  output logic             gap_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;
  localparam logic [CNT_W-1:0] GAP_AT  = GAP_LOW[CNT_W-1:0];

  logic             lvl_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_inc;

  assign run_inc = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= 1'b0;
      run_q      <= '0;
      hi_done_o  <= 1'b0;
      hi_width_o <= '0;
      gap_o      <= 1'b0;
    end else begin
      hi_done_o <= 1'b0;
      gap_o     <= 1'b0;
      if (sample_en_i) begin
        if (line_i != lvl_q) begin
          lvl_q <= line_i;
          run_q <= {{(CNT_W-1){1'b0}}, 1'b1};
          if (lvl_q) begin
            hi_done_o  <= 1'b1;
            hi_width_o <= run_q;
          end
        end else begin
          run_q <= run_inc;
          // fires once: the low run is about to exceed GAP_LOW
          if (!lvl_q && run_q == GAP_AT) gap_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/led_width_class.sv
module led_width_class
  import led_dec_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int ZERO_MIN = 2,
  parameter int ZERO_MAX = 3,
  parameter int ONE_MIN  = 6,
  parameter int ONE_MAX  = 8
) (
  input  logic [CNT_W-1:0] width_i,
  output pulse_kind_e      kind_o
);
  localparam logic [CNT_W-1:0] ZMN = ZERO_MIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ZMX = ZERO_MAX[CNT_W-1:0];
  localparam logic [CNT_W-1:0] OMN = ONE_MIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] OMX = ONE_MAX[CNT_W-1:0];

  logic in_zero, in_one;

  assign in_zero = (width_i >= ZMN) && (width_i <= ZMX);
  assign in_one  = (width_i >= OMN) && (width_i <= OMX);

  always_comb begin
    if (in_one)       kind_o = PK_ONE;
    else if (in_zero) kind_o = PK_ZERO;
    else              kind_o = PK_GLITCH;
  end
endmodule

// File: rtl/led_pixel_asm.sv
module led_pixel_asm
  import led_dec_pkg::*;
#(
  parameter int PIX_BITS = 24,
  parameter int CNT_W    = 9,
  parameter int BITCNT_W = 32,
  parameter int FRMCNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hi_done_i,
  input  logic [CNT_W-1:0]    hi_width_i,
  input  pulse_kind_e         kind_i,
  input  logic                gap_i,
  output logic                pixel_valid_o,
  output logic [PIX_BITS-1:0] pixel_data_o,
  output logic                frame_start_o,
  output logic                trunc_o,
  output logic                glitch_o,
  output logic [CNT_W-1:0]    glitch_width_o,
  output logic [BITCNT_W-1:0] bit_count_o,
  output logic [FRMCNT_W-1:0] frame_count_o
);
  localparam int IDX_W = $clog2(PIX_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PIX_BITS - 1);

  logic                synced_q;
  logic                start_pend_q;
  logic [IDX_W-1:0]    idx_q;
  logic [PIX_BITS-1:0] sh_q;
  logic [PIX_BITS-1:0] sh_next;
  logic                bit_val;

  assign bit_val = (kind_i == PK_ONE);
  assign sh_next = {sh_q[PIX_BITS-2:0], bit_val};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q       <= 1'b0;
      start_pend_q   <= 1'b0;
      idx_q          <= '0;
      sh_q           <= '0;
      pixel_valid_o  <= 1'b0;
      pixel_data_o   <= '0;
      frame_start_o  <= 1'b0;
      trunc_o        <= 1'b0;
      glitch_o       <= 1'b0;
      glitch_width_o <= '0;
      bit_count_o    <= '0;
      frame_count_o  <= '0;
    end else begin
      pixel_valid_o <= 1'b0;
      frame_start_o <= 1'b0;
      trunc_o       <= 1'b0;
      glitch_o      <= 1'b0;
      if (gap_i) begin
        synced_q     <= 1'b1;
        start_pend_q <= 1'b1;
        if (idx_q != '0) trunc_o <= 1'b1;
        idx_q <= '0;
      end else if (hi_done_i && synced_q) begin
        if (kind_i == PK_GLITCH) begin
          glitch_o       <= 1'b1;
          glitch_width_o <= hi_width_i;
        end else begin
          bit_count_o <= bit_count_o + 1'b1;
          sh_q        <= sh_next;
          if (start_pend_q) begin
            start_pend_q  <= 1'b0;
            frame_start_o <= 1'b1;
            frame_count_o <= frame_count_o + 1'b1;
          end
          if (idx_q == IDX_LAST) begin
            idx_q         <= '0;
            pixel_valid_o <= 1'b1;
            pixel_data_o  <= sh_next;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/led_pulse_decoder.sv
module led_pulse_decoder
  import led_dec_pkg::*;
#(
  parameter int PIX_BITS = 24,
  parameter int GAP_LOW  = 400,
  parameter int ZERO_MIN = 2,
  parameter int ZERO_MAX = 3,
  parameter int ONE_MIN  = 6,
  parameter int ONE_MAX  = 8,
  parameter int CNT_W    = $clog2(GAP_LOW + 2),
  parameter int BITCNT_W = 32,
  parameter int FRMCNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_i,
  input  logic                sample_en_i,
  output logic                pixel_valid_o,
  output logic [PIX_BITS-1:0] pixel_data_o,
  output logic                frame_start_o,
  output logic                trunc_o,
  output logic                glitch_o,
  output logic [CNT_W-1:0]    glitch_width_o,
  output logic [BITCNT_W-1:0] bit_count_o,
  output logic [FRMCNT_W-1:0] frame_count_o
);
  logic             hi_done;
  logic [CNT_W-1:0] hi_width;
  logic             gap;
  pulse_kind_e      kind;

  led_run_meter #(.CNT_W(CNT_W), .GAP_LOW(GAP_LOW)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .sample_en_i(sample_en_i),
    .hi_done_o  (hi_done),
    .hi_width_o (hi_width),
    .gap_o      (gap)
  );

  led_width_class #(
    .CNT_W(CNT_W), .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
    .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX)
  ) u_class (
    .width_i(hi_width),
    .kind_o (kind)
  );

  led_pixel_asm #(
    .PIX_BITS(PIX_BITS), .CNT_W(CNT_W),
    .BITCNT_W(BITCNT_W), .FRMCNT_W(FRMCNT_W)
  ) u_asm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hi_done_i     (hi_done),
    .hi_width_i    (hi_width),
    .kind_i        (kind),
    .gap_i         (gap),
    .pixel_valid_o (pixel_valid_o),
    .pixel_data_o  (pixel_data_o),
    .frame_start_o (frame_start_o),
    .trunc_o       (trunc_o),
    .glitch_o      (glitch_o),
    .glitch_width_o(glitch_width_o),
    .bit_count_o   (bit_count_o),
    .frame_count_o (frame_count_o)
  );
endmodule

// File: rtl/led_pulse_decoder_chk.sv
module led_pulse_decoder_chk #(
  parameter int CNT_W    = 9,
  parameter int ZERO_MIN = 2,
  parameter int ZERO_MAX = 3,
  parameter int ONE_MIN  = 6,
  parameter int ONE_MAX  = 8,
  parameter int BITCNT_W = 32,
  parameter int FRMCNT_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sample_en_i,
  input logic                pixel_valid_o,
  input logic                frame_start_o,
  input logic                trunc_o,
  input logic                glitch_o,
  input logic [CNT_W-1:0]    glitch_width_o,
  input logic [BITCNT_W-1:0] bit_count_o,
  input logic [FRMCNT_W-1:0] frame_count_o
);
  localparam logic [CNT_W-1:0] ZMN = ZERO_MIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ZMX = ZERO_MAX[CNT_W-1:0];
  localparam logic [CNT_W-1:0] OMN = ONE_MIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] OMX = ONE_MAX[CNT_W-1:0];

  assert_glitch_out_of_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_o |-> (glitch_width_o < ZMN || (glitch_width_o > ZMX && glitch_width_o < OMN)
                  || glitch_width_o > OMX));

  assert_events_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({glitch_o, trunc_o, pixel_valid_o}));

  assert_frame_start_with_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (bit_count_o == $past(bit_count_o) + 1'b1)
                      && (frame_count_o == $past(frame_count_o) + 1'b1));

  assert_frame_count_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |-> $stable(frame_count_o));

  assert_bit_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_count_o == $past(bit_count_o)) || (bit_count_o == $past(bit_count_o) + 1'b1));

  assert_pixel_single_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pixel_valid_o |=> !pixel_valid_o);

  assert_events_follow_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glitch_o || trunc_o || pixel_valid_o || frame_start_o) |-> $past(sample_en_i, 2));
endmodule

bind led_pulse_decoder led_pulse_decoder_chk #(
  .CNT_W(CNT_W), .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
  .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX),
  .BITCNT_W(BITCNT_W), .FRMCNT_W(FRMCNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_en_i   (sample_en_i),
  .pixel_valid_o (pixel_valid_o),
  .frame_start_o (frame_start_o),
  .trunc_o       (trunc_o),
  .glitch_o      (glitch_o),
  .glitch_width_o(glitch_width_o),
  .bit_count_o   (bit_count_o),
  .frame_count_o (frame_count_o)
);

// File: tb/tb_led_pulse_decoder.sv
module tb_led_pulse_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line = 1'b0;
  logic        sen = 1'b0;
  logic        pixel_valid;
  logic [23:0] pixel_data;
  logic        frame_start;
  logic        trunc;
  logic        glitch;
  logic [8:0]  glitch_width;
  logic [31:0] bit_count;
  logic [15:0] frame_count;

  always #4 clk = ~clk;

  led_pulse_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .sample_en_i(sen),
    .pixel_valid_o(pixel_valid), .pixel_data_o(pixel_data),
    .frame_start_o(frame_start), .trunc_o(trunc), .glitch_o(glitch),
    .glitch_width_o(glitch_width), .bit_count_o(bit_count),
    .frame_count_o(frame_count)
  );

  int total = 0, bad = 0;
  int idle_cyc = 1;
  bit done = 1'b0;

  // reference model
  bit          m_sync = 0, m_pend = 0;
  int          m_idx = 0, m_bits = 0, m_frames = 0;
  logic [23:0] m_sh = '0;
  logic [23:0] pix_q[$];
  int          glt_q[$];
  int          frm_q[$];
  int          trc_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic seg(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line = lvl;
      sen  = 1'b1;
      @(negedge clk);
      sen = 1'b0;
      for (int k = 1; k < idle_cyc; k++) @(negedge clk);
    end
  endtask

  task automatic model_bit(input bit b);
    if (m_pend) begin
      m_frames++;
      frm_q.push_back(m_frames);
      m_pend = 0;
    end
    m_bits++;
    m_sh = {m_sh[22:0], b};
    m_idx++;
    if (m_idx == 24) begin
      pix_q.push_back(m_sh);
      m_idx = 0;
    end
  endtask

  task automatic pulse(input int w, input int lowlen);
    seg(1'b1, w);
    if (m_sync) begin
      if (w == 2 || w == 3) model_bit(1'b0);
      else if (w >= 6 && w <= 8) model_bit(1'b1);
      else glt_q.push_back(w > 511 ? 511 : w);
    end
    seg(1'b0, lowlen);
  endtask

  task automatic send_bit(input bit b);
    if (b) pulse(7, 3);
    else pulse(2, 8);
  endtask

  task automatic send_pixel(input logic [23:0] p);
    for (int i = 23; i >= 0; i--) send_bit(p[i]);
  endtask

  task automatic frame_gap();
    if (m_idx != 0) trc_q.push_back(1);
    m_idx  = 0;
    m_sync = 1;
    m_pend = 1;
    seg(1'b0, 410);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (pixel_valid) begin
        if (pix_q.size() == 0) chk(0, "R7 unexpected pixel", pixel_data, 0);
        else begin
          logic [23:0] e;
          e = pix_q.pop_front();
          chk(pixel_data == e, "R7 pixel data", pixel_data, e);
        end
      end
      if (glitch) begin
        if (glt_q.size() == 0) chk(0, "R3 unexpected glitch", glitch_width, 0);
        else begin
          int e;
          e = glt_q.pop_front();
          chk(glitch_width == 9'(e), "R3 glitch width", glitch_width, e);
        end
      end
      if (trunc) begin
        if (trc_q.size() == 0) chk(0, "R8 unexpected trunc", 1, 0);
        else begin
          void'(trc_q.pop_front());
          chk(1, "R8 trunc", 1, 1);
        end
      end
      if (frame_start) begin
        if (frm_q.size() == 0) chk(0, "R9 unexpected frame start", frame_count, 0);
        else begin
          int e;
          e = frm_q.pop_front();
          chk(frame_count == 16'(e), "R9 frame count at start", frame_count, e);
        end
      end
    end
  end

  initial begin
    #(8 * 180000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R6 reset state
    chk(bit_count == 0, "R6 reset bit_count", bit_count, 0);
    chk(frame_count == 0, "R6 reset frame_count", frame_count, 0);
    chk({pixel_valid, frame_start, trunc, glitch} == 4'b0, "R6 reset events",
        {pixel_valid, frame_start, trunc, glitch}, 0);

    // R6: no decode before first gap
    seg(1'b0, 5);
    pulse(7, 3);
    pulse(5, 3);
    pulse(2, 8);
    repeat (6) @(negedge clk);
    chk(bit_count == 0, "R6 pre-sync bits ignored", bit_count, 0);

    frame_gap();
    // R2 R7 R9: first pixel of frame
    send_pixel(24'hA5C3F0);
    // R2 window edges: 3 -> 0, 6 -> 1, 8 -> 1
    pulse(3, 5); pulse(6, 4); pulse(8, 2);
    for (int i = 0; i < 21; i++) send_bit(i[0]);
    // R3 R11: glitches in middle of pixel
    for (int i = 0; i < 12; i++) send_bit(i[1]);
    pulse(1, 6); pulse(4, 6); pulse(5, 6); pulse(9, 6);
    for (int i = 0; i < 12; i++) send_bit(!i[0]);
    // R1: slowed strobe, widths in samples
    idle_cyc = 4;
    send_pixel(24'h3C5A81);
    idle_cyc = 1;
    // R5: low of exactly 400 samples is not a gap
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    pulse(2, 400);
    send_bit(1'b1);
    for (int i = 0; i < 17; i++) send_bit(1'b0);
    // R8: partial pixel dropped on gap
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    frame_gap();
    send_pixel(24'h000001);
    // R9: two gaps, one frame start
    frame_gap();
    frame_gap();
    send_pixel(24'hFFFFFE);
    // R4: saturating width
    pulse(600, 4);
    send_pixel(24'h123456);
    // R8: gap on pixel boundary, no trunc
    frame_gap();
    send_pixel(24'h800000);

    repeat (10) @(negedge clk);
    chk(bit_count == 32'(m_bits), "R10 bit_count", bit_count, m_bits);
    chk(frame_count == 16'(m_frames), "R9 frame_count", frame_count, m_frames);
    chk(pix_q.size() == 0, "R7 pixels outstanding", pix_q.size(), 0);
    chk(glt_q.size() == 0, "R3 glitches outstanding", glt_q.size(), 0);
    chk(trc_q.size() == 0, "R8 truncs outstanding", trc_q.size(), 0);
    chk(frm_q.size() == 0, "R9 frame starts outstanding", frm_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule